// File: doc/BRIEF.md
# Gated Pulse-Width Measurement Counter

This block measures how long a gate input stays asserted. The width is counted in periods of a slow counter clock, which reaches the block as a one-cycle strobe on the system clock. Software arms the block by raising three enables together (run, clock and gate) while a 3-bit mode field selects the measurement mode. After that, the first assertion of the gate starts a measurement.

The first counter-clock strobe after the gate asserts loads the counter with all ones. Each later strobe lowers it by one. When the gate drops, the counter freezes, a gate-event flag rises and the on flag falls. The elapsed width in strobe periods is all ones minus the held count. The count saturates at zero.

The capture is single-shot. Gate activity after the first negation changes nothing until the run enable is cleared, which clears the count and flags for a new arming. A gate-level output mirrors the gate pin at all times.

Top module: `gate_width_meter`

## Requirements
- R1: After reset, count_o is all ones (16'hFFFF), and on_o and gate_evt_o are 0.
- R2: With run_en_i, clk_en_i and gate_en_i all 1 and mode_i equal to 3'b100, on_o becomes 1 on the next clock. With any other mode_i value, on_o stays 0. The enables and mode are examined only at arming.
- R3: Once the block is armed and the gate is seen asserted, the first tick_i strobe loads count_o with 16'hFFFF rather than decrementing.
- R4: While the gate stays asserted, each later tick_i strobe sampled with clk_en_i at 1 lowers count_o by exactly one, visible one clock after the strobe. Strobes while clk_en_i is 0 leave count_o unchanged.
- R5: One clock after the gate negates during a measurement, count_o holds its value, gate_evt_o is 1 and on_o is 0. This also applies when no strobe arrived while the gate was asserted, in which case count_o stays 16'hFFFF.
- R6: After the measurement ends, further gate assertions, negations and strobes leave count_o, on_o and gate_evt_o unchanged.
- R7: The count does not wrap. Once count_o reaches 0, later strobes leave it at 0.
- R8: gate_lvl_o always equals the level on gate_i.
- R9: One clock after run_en_i is 0, count_o is 16'hFFFF and on_o and gate_evt_o are 0. The block can then be armed again.
- R10: Strobes that arrive while the block is armed but before the gate asserts leave count_o at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per counter-clock falling edge |
| gate_i | input | 1 | Gate pin, active high by default |
| run_en_i | input | 1 | Run enable; clearing it re-arms the block |
| clk_en_i | input | 1 | Counter-clock enable |
| gate_en_i | input | 1 | Gate enable |
| mode_i | input | 3 | Mode select; 3'b100 selects measurement |
| count_o | output | 16 | Captured count value |
| on_o | output | 1 | Timer active flag |
| gate_evt_o | output | 1 | Gate negation seen (measurement done) |
| gate_lvl_o | output | 1 | Current gate pin level |

## Verification
The hardest state to reach from the ports is saturation at zero. It needs the gate held for 65,536 strobes, so the stimulus holds tick_i high on every cycle for that long and then keeps strobing to show the count stays at zero. A second hard case is a gate pulse that ends before any strobe arrives. The bench sets it up by raising and dropping the gate on consecutive clocks with tick_i low. A behavioural model is compared against the outputs on every clock throughout.

// File: rtl/gwm_pkg.sv
package gwm_pkg;
   typedef enum logic [1:0] {
      GWM_IDLE = 2'd0,
      GWM_WAIT = 2'd1,
      GWM_RUN  = 2'd2,
      GWM_DONE = 2'd3
   } gwm_state_e;
endpackage

// File: rtl/gwm_gate_cond.sv
module gwm_gate_cond #(
   parameter bit GATE_ACT_HIGH = 1'b1
) (
   input  logic gate_pin_i,
   output logic gate_act_o
);
   generate
      if (GATE_ACT_HIGH) begin : g_high
         assign gate_act_o = gate_pin_i;
      end else begin : g_low
         assign gate_act_o = ~gate_pin_i;
      end
   endgenerate
endmodule

// File: rtl/gwm_counter.sv
module gwm_counter #(
   parameter int WIDTH    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic             dec_i,
   output logic [WIDTH-1:0] cnt_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZERO     = {WIDTH{1'b0}};

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] dec_val;

   generate
      if (SATURATE) begin : g_sat
         assign dec_val = (cnt_q == ZERO) ? ZERO : cnt_q - 1'b1;
      end else begin : g_wrap
         assign dec_val = cnt_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ALL_ONES;
      end else if (clr_i || load_i) begin
         cnt_q <= ALL_ONES;
      end else if (dec_i) begin
         cnt_q <= dec_val;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/gwm_ctrl.sv
module gwm_ctrl
   import gwm_pkg::*;
#(
   parameter int MODE_W   = 3,
   parameter int MODE_SEL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en_i,
   input  logic              clk_en_i,
   input  logic              gate_en_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              tick_i,
   input  logic              gate_act_i,
   output logic              on_o,
   output logic              evt_o,
   output logic              clr_o,
   output logic              load_o,
   output logic              dec_o
);
   localparam logic [MODE_W-1:0] SEL = MODE_W'(MODE_SEL);

   gwm_state_e state_q, state_d;
   logic       loaded_q, loaded_d;
   logic       on_q, on_d;
   logic       evt_q, evt_d;
   logic       arm, step, count_ok;

   always_comb begin
      arm      = run_en_i & clk_en_i & gate_en_i & (mode_i == SEL);
      step     = tick_i & clk_en_i;
      count_ok = run_en_i & (state_q == GWM_RUN) & gate_act_i & step;
      clr_o    = ~run_en_i;
      load_o   = count_ok & ~loaded_q;
      dec_o    = count_ok & loaded_q;
   end

   always_comb begin
      state_d  = state_q;
      loaded_d = loaded_q;
      on_d     = on_q;
      evt_d    = evt_q;
      if (!run_en_i) begin
         state_d  = GWM_IDLE;
         loaded_d = 1'b0;
         on_d     = 1'b0;
         evt_d    = 1'b0;
      end else begin
         unique case (state_q)
            GWM_IDLE: if (arm) begin
               state_d = GWM_WAIT;
               on_d    = 1'b1;
            end
            GWM_WAIT: if (gate_act_i) state_d = GWM_RUN;
            GWM_RUN: begin
               if (!gate_act_i) begin
                  state_d = GWM_DONE;
                  on_d    = 1'b0;
                  evt_d   = 1'b1;
               end else if (step) begin
                  loaded_d = 1'b1;
               end
            end
            GWM_DONE: state_d = GWM_DONE;
            default:  state_d = GWM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= GWM_IDLE;
         loaded_q <= 1'b0;
         on_q     <= 1'b0;
         evt_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         loaded_q <= loaded_d;
         on_q     <= on_d;
         evt_q    <= evt_d;
      end
   end

   assign on_o  = on_q;
   assign evt_o = evt_q;
endmodule

// File: rtl/gate_width_meter.sv
module gate_width_meter #(
   parameter int WIDTH         = 16,
   parameter int MODE_W        = 3,
   parameter int MODE_SEL      = 4,
   parameter bit GATE_ACT_HIGH = 1'b1,
   parameter bit SATURATE      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              gate_i,
   input  logic              run_en_i,
   input  logic              clk_en_i,
   input  logic              gate_en_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [WIDTH-1:0]  count_o,
   output logic              on_o,
   output logic              gate_evt_o,
   output logic              gate_lvl_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gate_width_meter: WIDTH must be at least 2");
      end
      if (MODE_W < 1) begin : g_bad_mode_w
         $error("gate_width_meter: MODE_W must be at least 1");
      end
      if (MODE_SEL < 0 || MODE_SEL >= (1 << MODE_W)) begin : g_bad_sel
         $error("gate_width_meter: MODE_SEL does not fit in MODE_W bits");
      end
   endgenerate

   logic gate_act;
   logic clr, load, dec;

   gwm_gate_cond #(.GATE_ACT_HIGH(GATE_ACT_HIGH)) u_gate (
      .gate_pin_i (gate_i),
      .gate_act_o (gate_act)
   );

   gwm_ctrl #(.MODE_W(MODE_W), .MODE_SEL(MODE_SEL)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en_i   (run_en_i),
      .clk_en_i   (clk_en_i),
      .gate_en_i  (gate_en_i),
      .mode_i     (mode_i),
      .tick_i     (tick_i),
      .gate_act_i (gate_act),
      .on_o       (on_o),
      .evt_o      (gate_evt_o),
      .clr_o      (clr),
      .load_o     (load),
      .dec_o      (dec)
   );

   gwm_counter #(.WIDTH(WIDTH), .SATURATE(SATURATE)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .load_i (load),
      .dec_i  (dec),
      .cnt_o  (count_o)
   );

   assign gate_lvl_o = gate_i;
endmodule

// File: rtl/gwm_chk.sv
module gwm_chk #(
   parameter int WIDTH    = 16,
   parameter int MODE_W   = 3,
   parameter int MODE_SEL = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gate_i,
   input logic              run_en_i,
   input logic              clk_en_i,
   input logic              gate_en_i,
   input logic [MODE_W-1:0] mode_i,
   input logic [WIDTH-1:0]  count_o,
   input logic              on_o,
   input logic              gate_evt_o,
   input logic              gate_lvl_o
);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   // R2
   arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_o) |-> $past(run_en_i && clk_en_i && gate_en_i && (mode_i == MODE_W'(MODE_SEL))));

   // R5
   on_evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(on_o && gate_evt_o));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_evt_o && $past(gate_evt_o)) |-> $stable(count_o));

   // R4
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != $past(count_o)) |-> ((count_o == WIDTH'($past(count_o) - 1'b1)) || (count_o == ONES)));

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count_o) == '0) |-> ((count_o == '0) || (count_o == ONES)));

   // R9
   rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_en_i) |-> ((count_o == ONES) && !on_o && !gate_evt_o));

   // R8
   gate_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lvl_o == gate_i);
endmodule

bind gate_width_meter gwm_chk #(.WIDTH(WIDTH), .MODE_W(MODE_W), .MODE_SEL(MODE_SEL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gate_i     (gate_i),
   .run_en_i   (run_en_i),
   .clk_en_i   (clk_en_i),
   .gate_en_i  (gate_en_i),
   .mode_i     (mode_i),
   .count_o    (count_o),
   .on_o       (on_o),
   .gate_evt_o (gate_evt_o),
   .gate_lvl_o (gate_lvl_o)
);

// File: tb/gate_width_meter_tb.sv
module gate_width_meter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, gate_i = 1'b0;
   logic        run_en_i = 1'b0, clk_en_i = 1'b0, gate_en_i = 1'b0;
   logic [2:0]  mode_i = 3'b000;
   logic [15:0] count_o;
   logic        on_o, gate_evt_o, gate_lvl_o;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gate_width_meter u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
      .run_en_i(run_en_i), .clk_en_i(clk_en_i), .gate_en_i(gate_en_i),
      .mode_i(mode_i), .count_o(count_o), .on_o(on_o),
      .gate_evt_o(gate_evt_o), .gate_lvl_o(gate_lvl_o)
   );

   // behavioural reference model
   int m_st, m_cnt;
   bit m_ld, m_on, m_evt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 65535; m_ld = 0; m_on = 0; m_evt = 0;
      end else if (!run_en_i) begin
         m_st = 0; m_cnt = 65535; m_ld = 0; m_on = 0; m_evt = 0;
      end else begin
         case (m_st)
            0: if (clk_en_i && gate_en_i && mode_i == 3'd4) begin m_st = 1; m_on = 1; end
            1: if (gate_i) m_st = 2;
            2: if (!gate_i) begin m_st = 3; m_on = 0; m_evt = 1; end
               else if (tick_i && clk_en_i) begin
                  if (!m_ld) begin m_cnt = 65535; m_ld = 1; end
                  else if (m_cnt > 0) m_cnt = m_cnt - 1;
               end
            default: ;
         endcase
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         tests++;
         if (count_o !== m_cnt[15:0] || on_o !== m_on || gate_evt_o !== m_evt || gate_lvl_o !== gate_i) begin
            fails++;
            $display("FAIL MODEL(R1..R10) cnt=%h/%h on=%b/%b evt=%b/%b lvl=%b/%b",
                     count_o, m_cnt[15:0], on_o, m_on, gate_evt_o, m_evt, gate_lvl_o, gate_i);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      cyc(100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 count", count_o, 16'hFFFF);
      chk("R1 on", on_o, 0);
      chk("R1 evt", gate_evt_o, 0);
      // wrong mode must not arm
      run_en_i = 1; clk_en_i = 1; gate_en_i = 1; mode_i = 3'b010;
      cyc(2);
      chk("R2 wrong mode on", on_o, 0);
      run_en_i = 0; cyc(1);
      mode_i = 3'b100; run_en_i = 1;
      cyc(1);
      chk("R2 armed on", on_o, 1);
      tick_i = 1; cyc(4); tick_i = 0; cyc(1);
      chk("R10 pre-gate ticks", count_o, 16'hFFFF);
      gate_i = 1; cyc(1);
      chk("R8 gate level high", gate_lvl_o, 1);
      tick_i = 1; cyc(1);
      chk("R3 first tick loads", count_o, 16'hFFFF);
      cyc(5);
      chk("R4 five decrements", count_o, 16'hFFFA);
      clk_en_i = 0; cyc(3);
      chk("R4 clk_en low holds", count_o, 16'hFFFA);
      clk_en_i = 1; tick_i = 0; gate_i = 0; cyc(1);
      chk("R8 gate level low", gate_lvl_o, 0);
      chk("R5 hold count", count_o, 16'hFFFA);
      chk("R5 evt set", gate_evt_o, 1);
      chk("R5 on cleared", on_o, 0);
      chk("R5 width", 32'(16'hFFFF - count_o), 5);
      gate_i = 1; tick_i = 1; cyc(4); gate_i = 0; cyc(2); gate_i = 1; cyc(3); gate_i = 0; tick_i = 0; cyc(1);
      chk("R6 count unchanged", count_o, 16'hFFFA);
      chk("R6 flags unchanged", {30'd0, on_o, gate_evt_o}, 32'h1);
      run_en_i = 0; cyc(1);
      chk("R9 count cleared", count_o, 16'hFFFF);
      chk("R9 flags cleared", {30'd0, on_o, gate_evt_o}, 0);
      // gate pulse with no strobe
      run_en_i = 1; cyc(1);
      chk("R9 rearm on", on_o, 1);
      gate_i = 1; cyc(1); gate_i = 0; cyc(1);
      chk("R5 no-tick count", count_o, 16'hFFFF);
      chk("R5 no-tick evt", gate_evt_o, 1);
      // saturation run
      run_en_i = 0; cyc(1); run_en_i = 1; cyc(1);
      gate_i = 1; cyc(1);
      tick_i = 1; cyc(65536);
      chk("R7 reach zero", count_o, 0);
      cyc(6);
      chk("R7 stays zero", count_o, 0);
      tick_i = 0; gate_i = 0; cyc(1);
      chk("R5 evt after saturation", gate_evt_o, 1);
      cyc(2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule